// File: doc/BRIEF.md
# Bus machine-cycle T-state sequencer

This block runs the external bus of a small 8-bit processor. An instruction is carried out as a sequence of up to five machine cycles. Each machine cycle is a fixed run of T-states, and each T-state lasts one clock. The T-state register advances on the falling edge of `clk_i`. A fetch cycle lasts four T-states. Every other cycle type lasts three.

The caller holds `req_i` high with the cycle type, address, write data, a last-cycle flag and an extra-clock count. The request is taken at the falling edge that ends the current cycle, or at any falling edge while the bus is idle. The first cycle of every instruction is always an opcode fetch, whatever type the caller presents. Once the last machine cycle ends, the block can insert idle clocks for long instructions. A one-clock done pulse marks the end of the instruction.

Top module: `bus_cyc_seq`

## Requirements
- R1: While `rst_ni` is low and after its release with no request, all outputs are 0.
- R2: Type codes: 0 opcode fetch, 1 memory read, 2 memory write, 3 I/O read, 4 I/O write. Codes 5 to 7 behave as memory read.
- R3: A fetch cycle lasts 4 T-states and every other cycle lasts 3. A request present at the falling edge that ends a non-last cycle starts T1 of the next cycle right away. A request present at a falling edge while idle starts T1.
- R4: The first machine cycle of each instruction is an opcode fetch regardless of `type_i`.
- R5: An instruction ends after the cycle loaded with `last_i`=1, or after its fifth cycle, whichever comes first.
- R6: `addr_o` carries the cycle address during T1 to T3 and is 0 in T4, in extra clocks and when idle.
- R7: `rd_o` is high only in T2 of read-type cycles (fetch, memory read, I/O read). `wr_o` is high only in T2 of write cycles. `wdata_o` shows the write data while `wr_o` is high and is 0 otherwise.
- R8: `io_o` is high during T1 to T3 of I/O read and I/O write cycles only.
- R9: `rdata_o` takes `rdata_bus_i` at the falling edge that ends T3 of a read-type cycle, and holds its value otherwise.
- R10: The `extra_i` value loaded with the last cycle appends that many idle clocks after the last cycle.
- R11: `done_o` is high for exactly one clock: the final T-state of the last cycle when the extra count is 0, otherwise the last extra clock.
- R12: Outputs change only on falling edges of `clk_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock; T-states start on its falling edge |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_i | input | 1 | Cycle request |
| type_i | input | 3 | Cycle type code |
| addr_i | input | 16 | Cycle address |
| wdata_i | input | 8 | Write data |
| last_i | input | 1 | Requested cycle is the last of the instruction |
| extra_i | input | 2 | Idle clocks appended after the last cycle |
| rdata_bus_i | input | 8 | Read data from the bus |
| addr_o | output | 16 | Address bus |
| wdata_o | output | 8 | Write data bus |
| rd_o | output | 1 | Read strobe |
| wr_o | output | 1 | Write strobe |
| io_o | output | 1 | I/O (high) versus memory select |
| rdata_o | output | 8 | Captured read data |
| done_o | output | 1 | Instruction done pulse |

## Verification
The sweep runs instructions of one to five cycles, plus a six-cycle request that never raises `last_i`, each with every extra count from 0 to 3. Cycle type codes are derived arithmetically, so the sweep covers all eight codes, including the unused ones and the code presented with the first cycle. Instruction length separates the four-clock fetch from the three-clock cycles and exercises the five-cycle cap. The extra count moves the done pulse. Per-cycle addresses, write data and bus read values all differ, so a strobe, select or capture placed in the wrong T-state is caught. A dedicated check samples just before and just after a falling edge to confirm which edge moves the state.

// File: rtl/bus_seq_pkg.sv
package bus_seq_pkg;
  localparam logic [2:0] CYC_FETCH = 3'd0;
  localparam logic [2:0] CYC_MRD   = 3'd1;
  localparam logic [2:0] CYC_MWR   = 3'd2;
  localparam logic [2:0] CYC_IORD  = 3'd3;
  localparam logic [2:0] CYC_IOWR  = 3'd4;

  typedef enum logic [2:0] {
    TS_IDLE, TS_T1, TS_T2, TS_T3, TS_T4, TS_XTRA
  } tstate_e;

  function automatic logic cyc_is_wr(input logic [2:0] t);
    return (t == CYC_MWR) || (t == CYC_IOWR);
  endfunction

  function automatic logic cyc_is_io(input logic [2:0] t);
    return (t == CYC_IORD) || (t == CYC_IOWR);
  endfunction

  // unused codes fall back to memory read
  function automatic logic cyc_is_rd(input logic [2:0] t);
    return !cyc_is_wr(t);
  endfunction
endpackage

// File: rtl/bus_tstate_fsm.sv
module bus_tstate_fsm import bus_seq_pkg::*; #(
  parameter int NCYC_MAX = 5,
  parameter int XW       = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_i,
  input  logic          last_i,
  input  logic [XW-1:0] extra_i,
  input  logic          fetch_i,
  output tstate_e       st_o,
  output logic          load_o,
  output logic          first_o,
  output logic          done_o
);
  localparam int CW = $clog2(NCYC_MAX + 1);

  tstate_e       st_q, st_d;
  logic [CW-1:0] idx_q;
  logic [XW-1:0] xcnt_q;
  logic          last_q, in_instr_q;
  logic          end_t;

  assign end_t   = (st_q == TS_T3 && !fetch_i) || st_q == TS_T4;
  assign load_o  = req_i && (st_q == TS_IDLE || (end_t && !last_q));
  assign first_o = !in_instr_q;
  assign done_o  = (end_t && last_q && xcnt_q == '0) ||
                   (st_q == TS_XTRA && xcnt_q == XW'(1));
  assign st_o    = st_q;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      TS_IDLE: if (load_o) st_d = TS_T1;
      TS_T1:   st_d = TS_T2;
      TS_T2:   st_d = TS_T3;
      TS_T3:   st_d = fetch_i ? TS_T4 : TS_IDLE;
      TS_T4:   st_d = TS_IDLE;
      TS_XTRA: if (xcnt_q == XW'(1)) st_d = TS_IDLE;
      default: st_d = TS_IDLE;
    endcase
    if (end_t) begin
      if (last_q)      st_d = (xcnt_q != '0) ? TS_XTRA : TS_IDLE;
      else if (load_o) st_d = TS_T1;
      else             st_d = TS_IDLE;
    end
  end

  // T-states begin on the falling clock edge
  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q       <= TS_IDLE;
      idx_q      <= '0;
      xcnt_q     <= '0;
      last_q     <= 1'b0;
      in_instr_q <= 1'b0;
    end else begin
      st_q <= st_d;
      if (load_o) begin
        in_instr_q <= 1'b1;
        idx_q      <= idx_q + CW'(1);
        last_q     <= last_i || (idx_q == CW'(NCYC_MAX - 1));
        xcnt_q     <= extra_i;
      end else if (end_t && last_q) begin
        in_instr_q <= 1'b0;
        idx_q      <= '0;
      end else if (st_q == TS_XTRA) begin
        xcnt_q <= xcnt_q - XW'(1);
      end
    end
  end

  AST_T_ORDER: assert property (@(negedge clk_i) disable iff (!rst_ni)
    st_q == TS_T2 |-> $past(st_q) == TS_T1); // R3
  AST_FETCH_T4: assert property (@(negedge clk_i) disable iff (!rst_ni)
    st_q == TS_T4 |-> fetch_i && $past(st_q) == TS_T3); // R3
  AST_NCYC_CAP: assert property (@(negedge clk_i) disable iff (!rst_ni)
    idx_q <= CW'(NCYC_MAX)); // R5
  AST_DONE_PULSE: assert property (@(negedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R11
endmodule

// File: rtl/bus_cyc_latch.sv
module bus_cyc_latch import bus_seq_pkg::*; #(
  parameter int AW = 16,
  parameter int DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic          first_i,
  input  logic [2:0]    type_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          cap_i,
  input  logic [DW-1:0] rdata_bus_i,
  output logic [2:0]    typ_o,
  output logic [AW-1:0] addr_o,
  output logic [DW-1:0] wdata_o,
  output logic [DW-1:0] rdata_o
);
  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      typ_o   <= CYC_FETCH;
      addr_o  <= '0;
      wdata_o <= '0;
      rdata_o <= '0;
    end else begin
      if (load_i) begin
        typ_o   <= first_i ? CYC_FETCH : type_i;
        addr_o  <= addr_i;
        wdata_o <= wdata_i;
      end
      if (cap_i) rdata_o <= rdata_bus_i;
    end
  end

  AST_FIRST_FETCH: assert property (@(negedge clk_i) disable iff (!rst_ni)
    load_i && first_i |=> typ_o == CYC_FETCH); // R4
endmodule

// File: rtl/bus_strobe_dec.sv
module bus_strobe_dec import bus_seq_pkg::*; #(
  parameter int AW = 16,
  parameter int DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  tstate_e       st_i,
  input  logic [2:0]    typ_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic [AW-1:0] addr_o,
  output logic [DW-1:0] wdata_o,
  output logic          rd_o,
  output logic          wr_o,
  output logic          io_o,
  output logic          cap_o
);
  logic bus_act;

  assign bus_act = st_i == TS_T1 || st_i == TS_T2 || st_i == TS_T3;
  assign addr_o  = bus_act ? addr_i : '0;
  assign rd_o    = st_i == TS_T2 && cyc_is_rd(typ_i);
  assign wr_o    = st_i == TS_T2 && cyc_is_wr(typ_i);
  assign wdata_o = wr_o ? wdata_i : '0;
  assign io_o    = bus_act && cyc_is_io(typ_i);
  assign cap_o   = st_i == TS_T3 && cyc_is_rd(typ_i);

  AST_STROBE_EXCL: assert property (@(negedge clk_i) disable iff (!rst_ni)
    !(rd_o && wr_o)); // R7
  AST_STROBE_T2: assert property (@(negedge clk_i) disable iff (!rst_ni)
    (rd_o || wr_o) |=> !rd_o && !wr_o); // R7
endmodule

// File: rtl/bus_cyc_seq.sv
module bus_cyc_seq import bus_seq_pkg::*; #(
  parameter int AW       = 16,
  parameter int DW       = 8,
  parameter int XW       = 2,
  parameter int NCYC_MAX = 5
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_i,
  input  logic [2:0]    type_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          last_i,
  input  logic [XW-1:0] extra_i,
  input  logic [DW-1:0] rdata_bus_i,
  output logic [AW-1:0] addr_o,
  output logic [DW-1:0] wdata_o,
  output logic          rd_o,
  output logic          wr_o,
  output logic          io_o,
  output logic [DW-1:0] rdata_o,
  output logic          done_o
);
  tstate_e       st;
  logic          load, first, cap;
  logic [2:0]    typ;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] wdata_q;

  bus_tstate_fsm #(.NCYC_MAX(NCYC_MAX), .XW(XW)) u_fsm (
    .clk_i, .rst_ni, .req_i, .last_i, .extra_i,
    .fetch_i(typ == CYC_FETCH),
    .st_o(st), .load_o(load), .first_o(first), .done_o
  );

  bus_cyc_latch #(.AW(AW), .DW(DW)) u_latch (
    .clk_i, .rst_ni, .load_i(load), .first_i(first), .type_i, .addr_i,
    .wdata_i, .cap_i(cap), .rdata_bus_i,
    .typ_o(typ), .addr_o(addr_q), .wdata_o(wdata_q), .rdata_o
  );

  bus_strobe_dec #(.AW(AW), .DW(DW)) u_dec (
    .clk_i, .rst_ni, .st_i(st), .typ_i(typ), .addr_i(addr_q),
    .wdata_i(wdata_q), .addr_o, .wdata_o, .rd_o, .wr_o, .io_o, .cap_o(cap)
  );

  AST_DONE_IDLE_BUS: assert property (@(negedge clk_i) disable iff (!rst_ni)
    done_o |-> !rd_o && !wr_o); // R11
endmodule

// File: tb/tb_bus_cyc_seq.sv
module tb_bus_cyc_seq;
  logic        clk = 1'b0, rst_n = 1'b0;
  logic        req = 1'b0, last = 1'b0;
  logic [2:0]  typ = '0;
  logic [15:0] addr = '0;
  logic [7:0]  wdata = '0, rbus = '0;
  logic [1:0]  extra = '0;
  logic [15:0] addr_o;
  logic [7:0]  wdata_o, rdata_o;
  logic        rd_o, wr_o, io_o, done_o;
  int n_tests = 0, n_fail = 0;
  bit chk_rd = 0;
  logic [7:0] exp_rd = '0;

  always #5 clk = ~clk;

  bus_cyc_seq dut (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .type_i(typ), .addr_i(addr),
    .wdata_i(wdata), .last_i(last), .extra_i(extra), .rdata_bus_i(rbus),
    .addr_o, .wdata_o, .rd_o, .wr_o, .io_o, .rdata_o, .done_o
  );

  task automatic chk(input bit ok, input string r, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h t=%0t", r, act, exp, $time);
    end
  endtask

  function automatic logic [2:0] code_of(int s, int k);
    return 3'((s * 3 + k * 5) % 8);
  endfunction

  task automatic expect_bus(input logic [15:0] a, input logic [7:0] w, input bit r,
                            input bit wr, input bit io, input bit dn);
    if (chk_rd) begin
      chk(rdata_o == exp_rd, "R9 rdata", rdata_o, exp_rd);
      chk_rd = 0;
    end
    chk(addr_o == a, "R6 addr", addr_o, a);
    chk(rd_o == r, "R7 rd", rd_o, r);
    chk(wr_o == wr, "R7 wr", wr_o, wr);
    chk(wdata_o == w, "R7 wdata", wdata_o, w);
    chk(io_o == io, "R8 io", io_o, io);
    chk(done_o == dn, "R11 done", done_o, dn);
  endtask

  task automatic load_cyc(input int s, input int k, input int n, input int x);
    typ   = code_of(s, k);
    addr  = 16'(16'h1100 * (k + 1) + s * 7);
    wdata = 8'(s * 13 + k * 29 + 1);
    last  = (k == n - 1);
    extra = 2'(x);
  endtask

  // R2 R3 R4 R5 R10
  task automatic run_instr(input int n, input int s, input int x);
    int ne = (n > 5) ? 5 : n;
    #1 req = 1'b1;
    load_cyc(s, 0, n, x);
    for (int c = 0; c < ne; c++) begin
      logic [2:0] e = (c == 0) ? 3'd0 : code_of(s, c);
      bit isw = (e == 3'd2 || e == 3'd4);
      bit isio = (e == 3'd3 || e == 3'd4);
      int len = (e == 3'd0) ? 4 : 3;
      logic [15:0] a = 16'(16'h1100 * (c + 1) + s * 7);
      logic [7:0] w = 8'(s * 13 + c * 29 + 1);
      logic [7:0] rv = 8'((s + c * 17) ^ 8'h5a);
      for (int t = 1; t <= len; t++) begin
        @(posedge clk);
        expect_bus(t <= 3 ? a : 16'h0, (t == 2 && isw) ? w : 8'h0,
                   t == 2 && !isw, t == 2 && isw, t <= 3 && isio,
                   c == ne - 1 && t == len && x == 0);
        if (t == 1) begin
          #1 rbus = rv;
          if (c == ne - 1) req = 1'b0;
          else load_cyc(s, c + 1, n, x);
        end
        if (t == 3 && !isw) begin
          chk_rd = 1;
          exp_rd = rv;
        end
      end
    end
    for (int e = 1; e <= x; e++) begin
      @(posedge clk);
      expect_bus(16'h0, 8'h0, 0, 0, 0, e == x); // R10
    end
    @(posedge clk);
    expect_bus(16'h0, 8'h0, 0, 0, 0, 0);
  endtask

  initial begin
    #200000;
    n_fail++;
    $display("FAIL watchdog act=0 exp=1");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (2) @(posedge clk);
    expect_bus(16'h0, 8'h0, 0, 0, 0, 0); // R1 in reset
    chk(rdata_o == 8'h0, "R1 rdata", rdata_o, 0);
    #1 rst_n = 1'b1;
    repeat (2) @(posedge clk);
    expect_bus(16'h0, 8'h0, 0, 0, 0, 0); // R1 after release
    // R12: request raised after a rising edge is seen only at the falling edge
    #1 req = 1'b1;
    load_cyc(1, 0, 1, 0);
    #2 chk(addr_o == 16'h0, "R12 before fall", addr_o, 0);
    #3 chk(addr_o == 16'h1107, "R12 after fall", addr_o, 16'h1107);
    req = 1'b0;
    repeat (5) @(posedge clk);
    chk(done_o == 1'b0, "R11 idle", done_o, 0);
    for (int n = 1; n <= 6; n++)
      for (int x = 0; x <= 3; x++)
        for (int s = 0; s < 2; s++)
          run_instr(n, n * 8 + x * 2 + s, x);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule